// File: doc/BRIEF.md
# Floppy Controller Interrupt Cause and Status-0 Tracker

This block sits beside the command sequencer of a floppy disk controller and keeps the record of why the controller's interrupt line is up. Events reach it as one-cycle strobes: a data command entering its result phase, a drive's ready line changing in either direction, a seek or recalibrate finishing normally or abnormally, and a level that stays high while a non-DMA transfer asks for data. It keeps a pending flag for each drive and each kind of event. It raises the interrupt while any of these is outstanding.

The sequencer hands the block each command it has decoded, in the form of a command-kind code on a valid/ready handshake. When the command is the interrupt status query, the block picks one pending seek or ready-line event, retires it, and answers with the status-0 byte on a valid/ready output stream. An undefined command gets the byte 80H. So does any command that is not the status query while a seek or recalibrate completion is still waiting to be acknowledged. The main-status direction bit (DIO) and request-for-master bit (RQM) follow from the state of that output stream.

Back-pressure rules: `cmd_ready` is low while a status byte waits to be taken or while the execution phase is running. A command counts as accepted only in a cycle where both `cmd_valid` and `cmd_ready` are high. `st0_valid`, once raised, stays high and `st0_byte` stays stable until the cycle in which `st0_ready` is high.

Top module: `fdc_irq_tracker`

## Requirements
- R1: After reset `irq`, `st0_valid` and `dio` are low, and `rqm` and `cmd_ready` are high.
- R2: A `result_enter_stb` pulse raises `irq` from the following cycle. It stays raised until a `result_rd_stb` pulse or an accepted status query.
- R3: While `ndma_req` is high, `irq` is high in the same cycle.
- R4: A normal seek/recalibrate end on drive d (strobe with `seek_abn`=0) keeps `irq` high. The status query then returns 20H plus d: bit 7 is 0, bit 6 is 0, bit 5 is 1, and bits 1:0 hold d.
- R5: An abnormal end on drive d (`seek_abn`=1) makes the status query return 60H plus d: bit 7 is 0, bit 6 is 1, bit 5 is 1, and bits 1:0 hold d.
- R6: A ready-line change strobe for drive d, whatever its polarity, makes the status query return C0H plus d: bit 7 is 1, bit 6 is 1, bit 5 is 0, and bits 1:0 hold d.
- R7: Each status query retires exactly one event. Seek completions come first, lowest drive number first. Ready-line changes follow, also lowest drive first. `irq` stays high until none remain.
- R8: A status query with nothing pending returns 80H.
- R9: A command of kind 7 (undefined; the kind codes are 0 status query, 1 seek/recalibrate, 2 data transfer, 3 other valid command) returns 80H. It leaves `irq` and every pending event unchanged.
- R10: A command of kind 1, 2 or 3 accepted while any seek completion is pending returns 80H and keeps that completion pending. With no seek completion pending, the same command produces no status byte.
- R11: `st0_valid` rises in the cycle after the command is accepted. While `st0_valid` is high, `dio` and `rqm` are high and `cmd_ready` is low.
- R12: While `exec_busy` is high and no status byte is waiting, `rqm` and `cmd_ready` are low.
- R13: An event on drive d in the same cycle as a status query that retires drive d's event of the same kind leaves that event pending with the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| result_enter_stb | input | 1 | Data command entered its result phase |
| result_rd_stb | input | 1 | Host read the first result byte |
| ndma_req | input | 1 | Non-DMA execution data request level |
| rdy_chg_stb | input | NDRV | Per-drive ready-line change strobes |
| seek_done_stb | input | 1 | Seek or recalibrate finished |
| seek_drv | input | DW | Drive number for seek_done_stb |
| seek_abn | input | 1 | Finish was abnormal |
| exec_busy | input | 1 | Execution phase in progress |
| cmd_valid | input | 1 | Command kind offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_kind | input | 3 | Decoded command kind |
| st0_valid | output | 1 | Status-0 byte available |
| st0_ready | input | 1 | Host takes the status byte |
| st0_byte | output | 8 | Status-0 byte |
| irq | output | 1 | Interrupt line |
| dio | output | 1 | Main-status data direction bit |
| rqm | output | 1 | Main-status request-for-master bit |

## Verification
An event strobe or an accepted command is seen at the next rising edge. The pending flags, the interrupt line and the status byte are all valid one cycle later. `ndma_req` is the only input that reaches `irq` in the same cycle. The bench applies every stimulus two nanoseconds after a rising edge, lets one edge pass, and compares at the same offset after that edge, with no waiting of its own in between. While a status byte sits unaccepted, the bench checks it again on every held cycle, so an early or late change would be seen.

// File: rtl/fdc_irq_pkg.sv
package fdc_irq_pkg;

  typedef enum logic [2:0] {
    CK_SENSE = 3'd0,
    CK_SEEK  = 3'd1,
    CK_DATA  = 3'd2,
    CK_MISC  = 3'd3,
    CK_UNDEF = 3'd7
  } cmd_kind_e;

  localparam logic [7:0] ST0_INVALID = 8'h80;

  // Interrupt code carried in status-0 bits 7:5
  localparam logic [2:0] IC_SEEK_OK  = 3'b001;
  localparam logic [2:0] IC_SEEK_BAD = 3'b011;
  localparam logic [2:0] IC_READY    = 3'b110;

  function automatic logic [7:0] st0_pack(input logic [2:0] code, input logic [1:0] drv);
    return {code, 3'b000, drv};
  endfunction

endpackage

// File: rtl/fdc_evt_pend.sv
// Per-drive pending-event flags with an optional payload bit field.
// A set in the same cycle as a clear of the same drive wins.
module fdc_evt_pend #(
  parameter int NDRV = 4,
  parameter int PW   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDRV-1:0] set_vec,
  input  logic [PW-1:0]   set_data,
  input  logic [NDRV-1:0] clr_vec,
  output logic [NDRV-1:0] pend,
  output logic [PW-1:0]   data [NDRV]
);

  for (genvar d = 0; d < NDRV; d++) begin : g_drv
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[d] <= 1'b0;
        data[d] <= '0;
      end else if (set_vec[d]) begin
        pend[d] <= 1'b1;
        data[d] <= set_data;
      end else if (clr_vec[d]) begin
        pend[d] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fdc_pick_lowest.sv
// Finds the lowest-numbered set bit of a request vector.
module fdc_pick_lowest #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);

  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx    = IW'(i);
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
    any = |req;
  end

endmodule

// File: rtl/fdc_st0_port.sv
// One-entry output register for the status-0 byte, valid/ready.
module fdc_st0_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_byte
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_byte  <= load_byte;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fdc_irq_tracker.sv
module fdc_irq_tracker
  import fdc_irq_pkg::*;
#(
  parameter int NDRV = 4,
  parameter int DW   = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            result_enter_stb,
  input  logic            result_rd_stb,
  input  logic            ndma_req,
  input  logic [NDRV-1:0] rdy_chg_stb,
  input  logic            seek_done_stb,
  input  logic [DW-1:0]   seek_drv,
  input  logic            seek_abn,
  input  logic            exec_busy,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_kind,
  output logic            st0_valid,
  input  logic            st0_ready,
  output logic [7:0]      st0_byte,
  output logic            irq,
  output logic            dio,
  output logic            rqm
);

  logic            accept, is_sense, sense_ok, invalid, load;
  logic [7:0]      load_byte;
  logic [NDRV-1:0] seek_set, seek_clr, seek_pend, seek_oh;
  logic [NDRV-1:0] rdy_clr, rdy_pend, rdy_oh;
  logic [0:0]      seek_data [NDRV];
  logic [0:0]      rdy_data  [NDRV];
  logic            seek_any, rdy_any;
  logic [DW-1:0]   seek_idx, rdy_idx;
  logic            res_irq;

  assign accept   = cmd_valid && cmd_ready;
  assign is_sense = (cmd_kind == CK_SENSE);
  assign sense_ok = accept && is_sense;
  assign invalid  = accept && ((cmd_kind == CK_UNDEF) || (!is_sense && seek_any));
  assign load     = sense_ok || invalid;

  always_comb begin
    seek_set = '0;
    if (seek_done_stb) seek_set[seek_drv] = 1'b1;
  end

  assign seek_clr = (sense_ok && seek_any) ? seek_oh : '0;
  assign rdy_clr  = (sense_ok && !seek_any && rdy_any) ? rdy_oh : '0;

  fdc_evt_pend #(.NDRV(NDRV), .PW(1)) u_seek_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(seek_set), .set_data(seek_abn),
    .clr_vec(seek_clr), .pend(seek_pend), .data(seek_data)
  );

  fdc_evt_pend #(.NDRV(NDRV), .PW(1)) u_rdy_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(rdy_chg_stb), .set_data(1'b1),
    .clr_vec(rdy_clr), .pend(rdy_pend), .data(rdy_data)
  );

  fdc_pick_lowest #(.N(NDRV), .IW(DW)) u_seek_pick (
    .req(seek_pend), .any(seek_any), .idx(seek_idx), .onehot(seek_oh)
  );

  fdc_pick_lowest #(.N(NDRV), .IW(DW)) u_rdy_pick (
    .req(rdy_pend), .any(rdy_any), .idx(rdy_idx), .onehot(rdy_oh)
  );

  always_comb begin
    load_byte = ST0_INVALID;
    if (!invalid && seek_any)
      load_byte = st0_pack(seek_data[seek_idx][0] ? IC_SEEK_BAD : IC_SEEK_OK, 2'(seek_idx));
    else if (!invalid && rdy_any)
      load_byte = st0_pack(IC_READY, 2'(rdy_idx));
  end

  fdc_st0_port u_port (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte),
    .out_ready(st0_ready), .out_valid(st0_valid), .out_byte(st0_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                        res_irq <= 1'b0;
    else if (result_enter_stb)         res_irq <= 1'b1;
    else if (result_rd_stb || sense_ok) res_irq <= 1'b0;
  end

  assign irq       = res_irq || ndma_req || seek_any || rdy_any;
  assign cmd_ready = !st0_valid && !exec_busy;
  assign dio       = st0_valid;
  assign rqm       = st0_valid || !exec_busy;

endmodule

// File: rtl/fdc_irq_chk.sv
module fdc_irq_chk #(
  parameter int NDRV = 4,
  parameter int DW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            result_enter_stb,
  input logic            ndma_req,
  input logic            seek_done_stb,
  input logic            seek_abn,
  input logic            exec_busy,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_kind,
  input logic            st0_valid,
  input logic            st0_ready,
  input logic [7:0]      st0_byte,
  input logic            irq,
  input logic            dio,
  input logic            rqm
);

  assert_result_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    result_enter_stb |=> irq);

  assert_ndma_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ndma_req |-> irq);

  assert_seek_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seek_done_stb |=> irq);

  assert_undef_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == 3'd7) |=> (st0_valid && st0_byte == 8'h80));

  assert_st0_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st0_valid && !st0_ready) |=> (st0_valid && $stable(st0_byte)));

  assert_st0_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st0_valid |-> (dio && rqm && !cmd_ready));

  assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_busy && !st0_valid) |-> (!rqm && !cmd_ready));

endmodule

bind fdc_irq_tracker fdc_irq_chk #(.NDRV(NDRV), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .result_enter_stb(result_enter_stb), .ndma_req(ndma_req),
  .seek_done_stb(seek_done_stb), .seek_abn(seek_abn), .exec_busy(exec_busy),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
  .st0_valid(st0_valid), .st0_ready(st0_ready), .st0_byte(st0_byte),
  .irq(irq), .dio(dio), .rqm(rqm)
);

// File: tb/sim_fdc_irq_tracker.sv
module sim_fdc_irq_tracker;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       result_enter_stb = 0, result_rd_stb = 0, ndma_req = 0;
  logic [3:0] rdy_chg_stb = 0;
  logic       seek_done_stb = 0, seek_abn = 0, exec_busy = 0;
  logic [1:0] seek_drv = 0;
  logic       cmd_valid = 0, st0_ready = 0;
  logic [2:0] cmd_kind = 0;
  logic       cmd_ready, st0_valid, irq, dio, rqm;
  logic [7:0] st0_byte;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  bit m_seek [4];
  bit m_abn  [4];
  bit m_rdy  [4];
  bit m_res;

  always #4 clk = ~clk;

  fdc_irq_tracker #(.NDRV(4)) u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  function automatic bit m_seek_any();
    for (int d = 0; d < 4; d++) if (m_seek[d]) return 1;
    return 0;
  endfunction

  function automatic bit m_irq();
    bit r = m_res | ndma_req;
    for (int d = 0; d < 4; d++) r |= m_seek[d] | m_rdy[d];
    return r;
  endfunction

  // status-query answer; retires the reported event in the model
  function automatic logic [7:0] m_sense_take();
    m_res = 0;
    for (int d = 0; d < 4; d++)
      if (m_seek[d]) begin
        m_seek[d] = 0;
        return {1'b0, m_abn[d], 1'b1, 3'b000, 2'(d)};
      end
    for (int d = 0; d < 4; d++)
      if (m_rdy[d]) begin
        m_rdy[d] = 0;
        return {3'b110, 3'b000, 2'(d)};
      end
    return 8'h80;
  endfunction

  task automatic seek_evt(int d, bit abn);
    seek_done_stb = 1; seek_drv = 2'(d); seek_abn = abn;
    step();
    seek_done_stb = 0;
    m_seek[d] = 1; m_abn[d] = abn;
    chk("R4 irq after seek end", irq, 1);
  endtask

  task automatic rdy_evt(int d);
    rdy_chg_stb = 4'(1 << d);
    step();
    rdy_chg_stb = 0;
    m_rdy[d] = 1;
    chk("R6 irq after ready change", irq, 1);
  endtask

  // take a pending status byte after a few held cycles
  task automatic drain(logic [7:0] exp, string req, int hold);
    chk({req, " st0_valid"}, st0_valid, 1);
    chk("R11 dio/rqm/cmd_ready while byte waits", {dio, rqm, cmd_ready}, 3'b110);
    for (int i = 0; i < hold; i++) begin
      step();
      chk({req, " held byte"}, st0_byte, exp);
    end
    chk({req, " byte"}, st0_byte, exp);
    st0_ready = 1;
    step();
    st0_ready = 0;
    chk("R11 st0_valid drops after take", st0_valid, 0);
  endtask

  task automatic issue(logic [2:0] kind, int hold);
    logic [7:0] exp;
    bit gives;
    string req;
    gives = 1;
    if (kind == 3'd7) begin exp = 8'h80; req = "R9"; end
    else if (kind == 3'd0) begin exp = m_sense_take(); req = (exp == 8'h80) ? "R8" : "R7"; end
    else if (m_seek_any()) begin exp = 8'h80; req = "R10"; end
    else begin gives = 0; exp = 0; req = "R10"; end
    cmd_valid = 1; cmd_kind = kind;
    step();
    cmd_valid = 0;
    if (gives) drain(exp, req, hold);
    else chk("R10 no byte for accepted command", st0_valid, 0);
    chk("R7 irq after command", irq, m_irq());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 reset outputs", {irq, st0_valid, dio, rqm, cmd_ready}, 5'b00011);

    // R8 empty query
    issue(3'd0, 0);
    // R2 result phase interrupt
    result_enter_stb = 1; step(); result_enter_stb = 0; m_res = 1;
    chk("R2 irq after result entry", irq, 1);
    step(); chk("R2 irq held", irq, 1);
    result_rd_stb = 1; step(); result_rd_stb = 0; m_res = 0;
    chk("R2 irq cleared by result read", irq, 0);
    // R3 non-DMA level
    ndma_req = 1; #1; chk("R3 irq same cycle", irq, 1);
    ndma_req = 0; #1; chk("R3 irq drops", irq, 0);
    step();
    // R4 R5 R6 R7 ordering
    rdy_evt(0); seek_evt(3, 0); seek_evt(1, 1);
    issue(3'd0, 2); // 61 (R5)
    issue(3'd0, 0); // 23 (R4)
    chk("R7 irq held while ready change pending", irq, 1);
    issue(3'd0, 1); // C0 (R6)
    chk("R7 irq low when none remain", irq, 0);
    // R9 undefined keeps pending
    seek_evt(2, 0);
    issue(3'd7, 0);
    chk("R9 irq unchanged", irq, 1);
    // R10 other command while ack owed
    issue(3'd2, 0);
    issue(3'd1, 0);
    issue(3'd0, 0); // 22
    issue(3'd3, 0); // accepted, no byte
    // R13 collision on same drive
    seek_evt(0, 0);
    seek_done_stb = 1; seek_drv = 0; seek_abn = 1;
    cmd_valid = 1; cmd_kind = 3'd0;
    step();
    seek_done_stb = 0; cmd_valid = 0;
    chk("R13 reported old event", st0_byte, 8'h20);
    st0_ready = 1; step(); st0_ready = 0;
    chk("R13 event still pending", irq, 1);
    m_seek[0] = 1; m_abn[0] = 1;
    issue(3'd0, 0); // 60
    // R12 busy
    exec_busy = 1; step();
    chk("R12 rqm/cmd_ready low when busy", {rqm, cmd_ready}, 2'b00);
    exec_busy = 0; step();
    chk("R12 rqm back", {rqm, cmd_ready}, 2'b11);

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 2) seek_evt($urandom_range(0, 3), 1'($urandom_range(0, 1)));
      else if (op < 4) rdy_evt($urandom_range(0, 3));
      else if (op == 4) begin
        result_enter_stb = 1; step(); result_enter_stb = 0; m_res = 1;
        chk("R2 irq after result entry", irq, 1);
      end else if (op < 8) issue(3'd0, $urandom_range(0, 3));
      else begin
        int k = $urandom_range(0, 3);
        issue((k == 0) ? 3'd7 : 3'(k), $urandom_range(0, 2));
      end
      chk("R7 irq tracks pending events", irq, m_irq());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule